// File: doc/BRIEF.md
# Read-once secret word store

This block keeps a device-unique secret as a set of 32-bit words in discrete registers. The words are loaded from a parameter when the synchronous reset is applied. A simple read port exposes them: a select line, an 8-bit address, 32-bit read data and a ready flag. Each word has a sticky "already consumed" flag. The real value of a word can therefore leave the block at most once between resets. The words can be consumed in any order.

Access is only granted while the firmware-mode input is low, which means trusted firmware is running. A read that is refused, a read of a consumed word, a read outside the secret window and an idle bus all return zeros. Holding the select line high does not extend the exposure. The flag sets on the first clock edge of the access, and from the next cycle the data is zero.

Top module: `onceKeyStore`

## Requirements
- R1: While reset (rstN low) is applied with select low, ready is 0 and read data is 0.
- R2: With select high and firmware mode low, the first read of word i (address 0x10+i, i = 0..7) returns bits [32*i+31 : 32*i] of the secret parameter in the same cycle.
- R3: After a word has returned its value once, every later read of it returns 0 until reset. This includes the cycle after the first read when select stays high.
- R4: Consuming one word has no effect on the others. The words can be consumed in any order, and each still returns its own value once.
- R5: With firmware mode high, a read of any secret address returns 0 and does not consume the word. A later read with firmware mode low still returns the secret.
- R6: A read at an address outside 0x10..0x17 returns 0, raises ready and consumes no word.
- R7: A reset clears every consumed flag, so each word can return its value once more.
- R8: Ready equals select in the same cycle, whatever the address or mode.
- R9: Read data is 0 whenever select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset; clears flags and reloads words |
| fwAppMode | input | 1 | High while application code runs; blocks secret access |
| cs | input | 1 | Read select |
| addr | input | 8 | Read address |
| rdData | output | 32 | Read data, zero unless access is granted |
| ready | output | 1 | Read acknowledge, same cycle as select |

## Verification
The bench keeps select high across back-to-back reads of the same word. A design that updates its flag late, or only when select falls, would leak the secret in a second cycle. Reads made with firmware mode high are later repeated with the mode low, which exposes a design that consumes a word on a refused read. Addresses just below and just above the window (0x0F, 0x18) exercise the range edges, where an off-by-one would either leak a neighbouring word or burn a flag. Random reads mixed with resets catch flags that survive reset or cross from one word to another.

// File: rtl/onceKeyPkg.sv
package onceKeyPkg;
  localparam int KEY_WORDS  = 8;
  localparam int KEY_WORD_W = 32;
  localparam int BUS_ADDR_W = 8;
  localparam int IDX_W      = $clog2(KEY_WORDS);
  localparam int KEY_BITS   = KEY_WORDS * KEY_WORD_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic             grant;  // expose the selected word this cycle
    logic [IDX_W-1:0] idx;    // which word
  } keyStrobeT;
endpackage

// File: rtl/onceKeyCtrl.sv
module onceKeyCtrl
  import onceKeyPkg::*;
#(
  parameter logic [BUS_ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fwAppMode,
  input  logic                 cs,
  input  logic [BUS_ADDR_W-1:0] addr,
  output keyStrobeT            strobe,
  output logic [KEY_WORDS-1:0] readFlags
);
  localparam int OFFS_W = BUS_ADDR_W + 1;

  logic [OFFS_W-1:0] offset;
  logic              inWindow;
  logic [IDX_W-1:0]  wordIdx;
  logic              grant;

  always_comb begin
    offset   = {1'b0, addr} - {1'b0, BASE_ADDR};
    inWindow = (addr >= BASE_ADDR) && (offset < OFFS_W'(KEY_WORDS));
    wordIdx  = offset[IDX_W-1:0];
    grant    = cs && inWindow && !fwAppMode && !readFlags[wordIdx];
  end

  assign strobe.grant = grant;
  assign strobe.idx   = wordIdx;

  // One sticky consumed flag per word
  for (genvar g = 0; g < KEY_WORDS; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)
        readFlags[g] <= 1'b0;
      else if (grant && (wordIdx == IDX_W'(g)))
        readFlags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/onceKeyData.sv
module onceKeyData
  import onceKeyPkg::*;
#(
  parameter logic [KEY_BITS-1:0] SECRET_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  keyStrobeT             strobe,
  output logic [KEY_WORD_W-1:0] rdData
);
  logic [KEY_WORD_W-1:0] words [KEY_WORDS];

  for (genvar g = 0; g < KEY_WORDS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN)
        words[g] <= SECRET_INIT[g*KEY_WORD_W +: KEY_WORD_W];
    end
  end

  // Zero unless control grants this cycle
  always_comb begin
    rdData = '0;
    if (strobe.grant)
      rdData = words[strobe.idx];
  end
endmodule

// File: rtl/onceKeyStore.sv
module onceKeyStore
  import onceKeyPkg::*;
#(
  parameter logic [BUS_ADDR_W-1:0] BASE_ADDR   = 8'h10,
  parameter logic [KEY_BITS-1:0]   SECRET_INIT =
    256'h3c5a7e11_2b49d6a0_91f0c3e7_5d2e8b14_a6b7c8d9_0e1f2a3b_4c5d6e7f_1a2b3c4d
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fwAppMode,
  input  logic                  cs,
  input  logic [BUS_ADDR_W-1:0] addr,
  output logic [KEY_WORD_W-1:0] rdData,
  output logic                  ready
);
  keyStrobeT            strobe;
  logic [KEY_WORDS-1:0] readFlags;

  onceKeyCtrl #(.BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .fwAppMode(fwAppMode), .cs(cs), .addr(addr),
    .strobe(strobe), .readFlags(readFlags)
  );

  onceKeyData #(.SECRET_INIT(SECRET_INIT)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData)
  );

  assign ready = cs;
endmodule

// File: rtl/onceKeyChecker.sv
module onceKeyChecker
  import onceKeyPkg::*;
#(
  parameter logic [BUS_ADDR_W-1:0] BASE_ADDR   = 8'h10,
  parameter logic [KEY_BITS-1:0]   SECRET_INIT = '0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  fwAppMode,
  input logic                  cs,
  input logic [BUS_ADDR_W-1:0] addr,
  input logic [KEY_WORD_W-1:0] rdData,
  input logic                  ready,
  input logic [KEY_WORDS-1:0]  readFlags
);
  logic [BUS_ADDR_W:0] chkOffs;
  logic                chkIn;
  logic [IDX_W-1:0]    chkIdx;
  assign chkOffs = {1'b0, addr} - {1'b0, BASE_ADDR};
  assign chkIn   = (addr >= BASE_ADDR) && (chkOffs < (BUS_ADDR_W+1)'(KEY_WORDS));
  assign chkIdx  = chkOffs[IDX_W-1:0];

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cs && chkIn && !fwAppMode && !readFlags[chkIdx]) |->
      (rdData == SECRET_INIT[chkIdx*KEY_WORD_W +: KEY_WORD_W]));

  assert_no_repeat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cs && $past(cs) && (addr == $past(addr)) && ($past(rdData) != '0)) |->
      (rdData == '0));

  assert_consumed_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cs && chkIn && readFlags[chkIdx]) |-> (rdData == '0));

  assert_mode_block_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cs && fwAppMode) |=> ($stable(readFlags) || !rstN));

  assert_mode_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cs && fwAppMode) |-> (rdData == '0));

  assert_outside_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cs && !chkIn) |-> (rdData == '0 && ready));

  assert_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    ready == cs);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cs |-> (rdData == '0));
endmodule

bind onceKeyStore onceKeyChecker #(.BASE_ADDR(BASE_ADDR), .SECRET_INIT(SECRET_INIT)) u_chk (
  .clk(clk), .rstN(rstN), .fwAppMode(fwAppMode), .cs(cs), .addr(addr),
  .rdData(rdData), .ready(ready), .readFlags(readFlags)
);

// File: tb/test_onceKeyStore.sv
`timescale 1ns/1ps
module test_onceKeyStore;
  localparam logic [255:0] SECRET =
    256'h3c5a7e11_2b49d6a0_91f0c3e7_5d2e8b14_a6b7c8d9_0e1f2a3b_4c5d6e7f_1a2b3c4d;
  localparam logic [7:0] BASE = 8'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fwAppMode = 1'b0;
  logic        cs = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] rdData;
  logic        ready;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [7:0] expFlags = '0;

  always #10 clk = ~clk;  // 50 MHz

  onceKeyStore #(.BASE_ADDR(BASE), .SECRET_INIT(SECRET)) i_onceKeyStore (
    .clk(clk), .rstN(rstN), .fwAppMode(fwAppMode), .cs(cs), .addr(addr),
    .rdData(rdData), .ready(ready)
  );

  function automatic bit inWin(input logic [7:0] a);
    return (a >= BASE) && (a < BASE + 8'd8);
  endfunction

  function automatic logic [31:0] expData(input logic [7:0] a, input logic m,
                                          input logic [7:0] f);
    logic [2:0] i;
    i = 3'(a - BASE);
    if (inWin(a) && !m && !f[i]) return SECRET[i*32 +: 32];
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // One read cycle; the model flag takes effect at the following edge
  task automatic doRead(input logic [7:0] a, input logic m, input string tagIn);
    logic [31:0] e;
    string tag;
    @(negedge clk);
    cs = 1'b1; addr = a; fwAppMode = m;
    #5;
    e = expData(a, m, expFlags);
    tag = tagIn;
    if (tag == "") begin
      if (!inWin(a)) tag = "R6";
      else if (m) tag = "R5";
      else if (expFlags[3'(a - BASE)]) tag = "R3";
      else tag = "R2";
    end
    check(rdData == e, tag, rdData, e);
    check(ready == 1'b1, "R8", {31'b0, ready}, 32'h1);
    if (inWin(a) && !m) expFlags[3'(a - BASE)] = 1'b1;
  endtask

  task automatic doIdle(input logic [7:0] a, input logic m);
    @(negedge clk);
    cs = 1'b0; addr = a; fwAppMode = m;
    #5;
    check(rdData == 32'h0, "R9", rdData, 32'h0);
    check(ready == 1'b0, "R8", {31'b0, ready}, 32'h0);
  endtask

  task automatic doReset();
    @(negedge clk);
    cs = 1'b0; rstN = 1'b0;
    @(negedge clk);
    #5;
    check(rdData == 32'h0, "R1", rdData, 32'h0);
    check(ready == 1'b0, "R1", {31'b0, ready}, 32'h0);
    rstN = 1'b1;
    expFlags = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset();

    // R5: refused reads do not consume; then R2 reads succeed
    for (int i = 0; i < 8; i++) doRead(BASE + 8'(i), 1'b1, "R5");
    // R6: window edges, no flag burned
    doRead(8'h0F, 1'b0, "R6");
    doRead(8'h18, 1'b0, "R6");
    doRead(8'hFF, 1'b0, "R6");
    // R2 then R3 with select held high across repeated addresses
    doRead(BASE + 8'd0, 1'b0, "R2");
    doRead(BASE + 8'd0, 1'b0, "R3");
    doRead(BASE + 8'd7, 1'b0, "R2");
    doRead(BASE + 8'd7, 1'b0, "R3");
    doIdle(BASE + 8'd3, 1'b0);
    // R4: shuffled order over the rest
    doRead(BASE + 8'd5, 1'b0, "R4");
    doRead(BASE + 8'd2, 1'b0, "R4");
    doRead(BASE + 8'd6, 1'b0, "R4");
    doRead(BASE + 8'd1, 1'b0, "R4");
    doRead(BASE + 8'd4, 1'b0, "R4");
    doRead(BASE + 8'd3, 1'b0, "R4");
    for (int i = 0; i < 8; i++) doRead(BASE + 8'(i), 1'b0, "R3");

    // R7: reset restores every word
    doReset();
    for (int i = 7; i >= 0; i--) doRead(BASE + 8'(i), 1'b0, "R7");
    for (int i = 0; i < 8; i++) doRead(BASE + 8'(i), 1'b0, "R3");

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [7:0] a;
      logic m;
      r = int'($urandom_range(0, 99));
      a = (r < 80) ? 8'(int'($urandom_range(14, 25))) : 8'($urandom);
      m = ($urandom_range(0, 3) == 0);
      if (r < 3) doReset();
      else if (r < 12) doIdle(a, m);
      else doRead(a, m, "");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule